// File: doc/BRIEF.md
# Pipeline Hazard and Stall Controller

This unit sits beside the Decode stage of a five-stage in-order pipeline. It decides, cycle by cycle, whether the program counter and the fetch/decode pipeline register may advance. It also decides whether the control fields entering Execute must be cleared to make a bubble, and which address the program counter loads next. Two kinds of event need it. The first is a load whose destination is read by the very next instruction, which forwarding cannot cover. The second is a jump or a branch, because the branch outcome is only known in Execute.

A combinational detector compares the Execute-stage load destination with the source registers the Decode instruction really reads. A four-state machine (run, jump, branch-wait, branch-refetch) has a state register kept apart from its next-state and output logic, and it resets synchronously. Its outputs depend on both the state and the current inputs. After a branch, fetch is held for one cycle. The ALU zero flag then either lets the already-fetched sequential instruction go on, or restarts fetch at the branch target and squashes that instruction.

Top module: `hazard_stall_ctrl`

## Requirements
- R1: While `rst` is high at a rising clock edge, the machine returns to the run state, so the first cycle after reset with quiet inputs gives normal outputs, even if reset arrives in the middle of a branch sequence.
- R2: In the run state, with no jump, no branch and no load hazard, the outputs are `pc_we`=1, `ifid_we`=1, `bubble`=0 and `pc_sel`=00 (sequential address). `pc_sel` never takes the value 11.
- R3: A load hazard exists when `ex_mem_read` is 1 and `ex_rt` equals `id_rs`, or when `ex_mem_read` is 1 and `ex_rt` equals `id_rt`; a mismatch on both, or `ex_mem_read`=0, gives no hazard.
- R4: When `id_use_imm` or `id_use_shamt` is 1, a match on `id_rt` alone raises no hazard.
- R5: In the run state, a load hazard gives `pc_we`=0, `ifid_we`=0, `bubble`=1 and `pc_sel`=00 in that same cycle. The machine stays in the run state, so the stall lasts only as long as the hazard does.
- R6: In the run state, `jump`=1 gives `pc_we`=1, `ifid_we`=0, `bubble`=0 and `pc_sel`=01 (jump target). The next cycle gives `pc_we`=1, `ifid_we`=1, `bubble`=1 and `pc_sel`=00, and the cycle after that is back in the run state.
- R7: In the run state, `branch`=1 (without `jump`) gives `pc_we`=0, `ifid_we`=0, `bubble`=0 and `pc_sel`=00. Whenever `pc_we` is 0, `ifid_we` is also 0.
- R8: In the cycle after a branch is issued, `alu_zero`=1 gives `pc_we`=1, `ifid_we`=0, `bubble`=1 and `pc_sel`=10 (branch target). The next cycle gives `pc_we`=1, `ifid_we`=1, `bubble`=1 and `pc_sel`=00, and then the machine is back in the run state.
- R9: In the cycle after a branch is issued, `alu_zero`=0 gives `pc_we`=1, `ifid_we`=1, `bubble`=1 and `pc_sel`=00, and the next cycle is in the run state.
- R10: In the run state, `jump` wins over `branch`, and both win over a load hazard.
- R11: Outside the run state, `jump`, `branch` and the load hazard have no effect on the outputs or on the next state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| jump | input | 1 | Decode instruction is a jump |
| branch | input | 1 | Decode instruction is a conditional branch |
| alu_zero | input | 1 | ALU zero flag of the Execute-stage branch |
| ex_mem_read | input | 1 | Execute-stage instruction reads data memory |
| id_rs | input | AW | First source register of the Decode instruction |
| id_rt | input | AW | Second source register of the Decode instruction |
| ex_rt | input | AW | Destination (Rt) of the Execute-stage instruction |
| id_use_imm | input | 1 | Decode instruction takes an immediate in place of Rt |
| id_use_shamt | input | 1 | Decode instruction takes a shift amount in place of Rt |
| pc_we | output | 1 | Program counter write enable |
| ifid_we | output | 1 | Fetch/decode pipeline register write enable |
| bubble | output | 1 | Clear the control fields entering Execute |
| pc_sel | output | 2 | Next PC source: 00 sequential, 01 jump, 10 branch |

## Verification
Every output is a Mealy output, so the response to a stimulus is due in the same cycle as the stimulus, before the next rising edge. Effects that go through the state register appear one edge later. The bench drives inputs just after a falling edge and samples the outputs two nanoseconds later. Each table row therefore checks the combinational result for the state reached at the previous rising edge. The follow-on cycles of jumps and branches are checked in the rows that come next. Reset is checked in the first cycle after the reset edge.

// File: rtl/hzc_pkg.sv
package hzc_pkg;

  typedef enum logic [1:0] {
    ST_RUN = 2'd0,
    ST_JMP = 2'd1,
    ST_BR0 = 2'd2,
    ST_BR1 = 2'd3
  } hz_state_t;

  localparam int SEL_W = 2;

  localparam logic [SEL_W-1:0] SEL_SEQ = 2'b00;
  localparam logic [SEL_W-1:0] SEL_JMP = 2'b01;
  localparam logic [SEL_W-1:0] SEL_BRT = 2'b10;

  typedef struct packed {
    logic             pc_we;
    logic             ifid_we;
    logic             bubble;
    logic [SEL_W-1:0] sel;
  } stall_ctl_t;

  function automatic stall_ctl_t mk_ctl(input logic pc, input logic ifid,
                                        input logic bub, input logic [SEL_W-1:0] sel);
    stall_ctl_t c;
    c.pc_we   = pc;
    c.ifid_we = ifid;
    c.bubble  = bub;
    c.sel     = sel;
    return c;
  endfunction

endpackage

// File: rtl/hzc_load_detect.sv
module hzc_load_detect #(
  parameter int AW = 5
) (
  input  logic          ex_mem_read,
  input  logic [AW-1:0] id_rs,
  input  logic [AW-1:0] id_rt,
  input  logic [AW-1:0] ex_rt,
  input  logic          id_use_imm,
  input  logic          id_use_shamt,
  output logic          rs_clash,
  output logic          rt_clash,
  output logic          load_haz
);

  function automatic logic reg_clash(input logic rd, input logic [AW-1:0] dst,
                                     input logic [AW-1:0] src, input logic used);
    return rd && used && (dst == src);
  endfunction

  logic rt_used;

  always_comb begin
    rt_used  = !(id_use_imm || id_use_shamt);
    rs_clash = reg_clash(ex_mem_read, ex_rt, id_rs, 1'b1);
    rt_clash = reg_clash(ex_mem_read, ex_rt, id_rt, rt_used);
    load_haz = rs_clash || rt_clash;
  end

endmodule

// File: rtl/hzc_seq_fsm.sv
module hzc_seq_fsm
  import hzc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       jump,
  input  logic       branch,
  input  logic       alu_zero,
  input  logic       load_haz,
  output stall_ctl_t ctl,
  output logic       in_run,
  output logic       in_br1
);

  hz_state_t state_q, state_d;

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_RUN;
    else     state_q <= state_d;
  end

  always_comb begin
    state_d = state_q;
    ctl     = mk_ctl(1'b1, 1'b1, 1'b0, SEL_SEQ);
    unique case (state_q)
      ST_RUN: begin
        if (jump) begin
          ctl     = mk_ctl(1'b1, 1'b0, 1'b0, SEL_JMP);
          state_d = ST_JMP;
        end else if (branch) begin
          ctl     = mk_ctl(1'b0, 1'b0, 1'b0, SEL_SEQ);
          state_d = ST_BR0;
        end else if (load_haz) begin
          ctl     = mk_ctl(1'b0, 1'b0, 1'b1, SEL_SEQ);
        end
      end
      ST_JMP: begin
        ctl     = mk_ctl(1'b1, 1'b1, 1'b1, SEL_SEQ);
        state_d = ST_RUN;
      end
      ST_BR0: begin
        if (alu_zero) begin
          ctl     = mk_ctl(1'b1, 1'b0, 1'b1, SEL_BRT);
          state_d = ST_BR1;
        end else begin
          ctl     = mk_ctl(1'b1, 1'b1, 1'b1, SEL_SEQ);
          state_d = ST_RUN;
        end
      end
      ST_BR1: begin
        ctl     = mk_ctl(1'b1, 1'b1, 1'b1, SEL_SEQ);
        state_d = ST_RUN;
      end
      default: state_d = ST_RUN;
    endcase
  end

  assign in_run = (state_q == ST_RUN);
  assign in_br1 = (state_q == ST_BR1);

  AST_STALL_PAIR: assert property (@(posedge clk) disable iff (rst)
    !ctl.pc_we |-> !ctl.ifid_we); // R7

  AST_BR1_RETURN: assert property (@(posedge clk) disable iff (rst)
    in_br1 |=> in_run); // R8

endmodule

// File: rtl/hazard_stall_ctrl.sv
module hazard_stall_ctrl
  import hzc_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             jump,
  input  logic             branch,
  input  logic             alu_zero,
  input  logic             ex_mem_read,
  input  logic [AW-1:0]    id_rs,
  input  logic [AW-1:0]    id_rt,
  input  logic [AW-1:0]    ex_rt,
  input  logic             id_use_imm,
  input  logic             id_use_shamt,
  output logic             pc_we,
  output logic             ifid_we,
  output logic             bubble,
  output logic [SEL_W-1:0] pc_sel
);

  logic       rs_clash, rt_clash, load_haz;
  logic       in_run, in_br1;
  stall_ctl_t ctl;

  hzc_load_detect #(.AW(AW)) i_detect (
    .ex_mem_read (ex_mem_read),
    .id_rs       (id_rs),
    .id_rt       (id_rt),
    .ex_rt       (ex_rt),
    .id_use_imm  (id_use_imm),
    .id_use_shamt(id_use_shamt),
    .rs_clash    (rs_clash),
    .rt_clash    (rt_clash),
    .load_haz    (load_haz)
  );

  hzc_seq_fsm i_fsm (
    .clk     (clk),
    .rst     (rst),
    .jump    (jump),
    .branch  (branch),
    .alu_zero(alu_zero),
    .load_haz(load_haz),
    .ctl     (ctl),
    .in_run  (in_run),
    .in_br1  (in_br1)
  );

  assign pc_we   = ctl.pc_we;
  assign ifid_we = ctl.ifid_we;
  assign bubble  = ctl.bubble;
  assign pc_sel  = ctl.sel;

  AST_SEL_LEGAL: assert property (@(posedge clk) disable iff (rst)
    pc_sel != 2'b11); // R2

  AST_RS_MATCH: assert property (@(posedge clk) disable iff (rst)
    (ex_mem_read && ex_rt == id_rs) |-> load_haz); // R3

  AST_LOAD_BUBBLE: assert property (@(posedge clk) disable iff (rst)
    (in_run && load_haz && !jump && !branch) |-> (bubble && !pc_we && !ifid_we)); // R5

  AST_JUMP_SQUASH: assert property (@(posedge clk) disable iff (rst)
    (in_run && jump) |=> (bubble && pc_we && ifid_we && pc_sel == SEL_SEQ)); // R6

  AST_BR_RESOLVE: assert property (@(posedge clk) disable iff (rst)
    (in_run && branch && !jump) |=> (pc_we && bubble)); // R9

endmodule

// File: tb/test_hazard_stall_ctrl.sv
module test_hazard_stall_ctrl;

  typedef struct packed {
    logic       jmp;
    logic       br;
    logic       zero;
    logic       mrd;
    logic [4:0] rs;
    logic [4:0] rt;
    logic [4:0] prt;
    logic       imm;
    logic       sh;
    logic       e_pc;
    logic       e_if;
    logic       e_bub;
    logic [1:0] e_sel;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t TBL [0:NV-1] = '{
    '{1'b0,1'b0,1'b0,1'b0,5'd1,5'd2,5'd3,1'b0,1'b0, 1'b1,1'b1,1'b0,2'b00, 4'd2},  // R2 quiet
    '{1'b0,1'b0,1'b0,1'b1,5'd1,5'd2,5'd1,1'b0,1'b0, 1'b0,1'b0,1'b1,2'b00, 4'd3},  // R3 rs match
    '{1'b0,1'b0,1'b0,1'b0,5'd1,5'd2,5'd1,1'b0,1'b0, 1'b1,1'b1,1'b0,2'b00, 4'd5},  // R5 one cycle
    '{1'b0,1'b0,1'b0,1'b1,5'd1,5'd2,5'd2,1'b0,1'b0, 1'b0,1'b0,1'b1,2'b00, 4'd3},  // R3 rt match
    '{1'b0,1'b0,1'b0,1'b1,5'd1,5'd2,5'd2,1'b1,1'b0, 1'b1,1'b1,1'b0,2'b00, 4'd4},  // R4 imm
    '{1'b0,1'b0,1'b0,1'b1,5'd1,5'd2,5'd2,1'b0,1'b1, 1'b1,1'b1,1'b0,2'b00, 4'd4},  // R4 shamt
    '{1'b0,1'b0,1'b0,1'b1,5'd1,5'd2,5'd5,1'b0,1'b0, 1'b1,1'b1,1'b0,2'b00, 4'd3},  // R3 no match
    '{1'b1,1'b0,1'b0,1'b0,5'd1,5'd2,5'd3,1'b0,1'b0, 1'b1,1'b0,1'b0,2'b01, 4'd6},  // R6 jump
    '{1'b1,1'b0,1'b0,1'b0,5'd1,5'd2,5'd3,1'b0,1'b0, 1'b1,1'b1,1'b1,2'b00, 4'd11}, // R11 jump ignored
    '{1'b0,1'b0,1'b0,1'b0,5'd1,5'd2,5'd3,1'b0,1'b0, 1'b1,1'b1,1'b0,2'b00, 4'd6},  // R6 back
    '{1'b0,1'b1,1'b0,1'b0,5'd1,5'd2,5'd3,1'b0,1'b0, 1'b0,1'b0,1'b0,2'b00, 4'd7},  // R7 branch
    '{1'b0,1'b1,1'b0,1'b1,5'd1,5'd2,5'd1,1'b0,1'b0, 1'b1,1'b1,1'b1,2'b00, 4'd9},  // R9 not taken
    '{1'b0,1'b0,1'b0,1'b0,5'd1,5'd2,5'd3,1'b0,1'b0, 1'b1,1'b1,1'b0,2'b00, 4'd9},  // R9 back
    '{1'b0,1'b1,1'b0,1'b0,5'd1,5'd2,5'd3,1'b0,1'b0, 1'b0,1'b0,1'b0,2'b00, 4'd7},  // R7 branch
    '{1'b1,1'b0,1'b1,1'b0,5'd1,5'd2,5'd3,1'b0,1'b0, 1'b1,1'b0,1'b1,2'b10, 4'd8},  // R8 taken
    '{1'b0,1'b1,1'b1,1'b1,5'd1,5'd2,5'd1,1'b0,1'b0, 1'b1,1'b1,1'b1,2'b00, 4'd11}, // R11 in refetch
    '{1'b0,1'b0,1'b0,1'b0,5'd1,5'd2,5'd3,1'b0,1'b0, 1'b1,1'b1,1'b0,2'b00, 4'd8},  // R8 back
    '{1'b1,1'b1,1'b0,1'b1,5'd1,5'd2,5'd1,1'b0,1'b0, 1'b1,1'b0,1'b0,2'b01, 4'd10}, // R10 jump wins
    '{1'b0,1'b0,1'b0,1'b0,5'd1,5'd2,5'd3,1'b0,1'b0, 1'b1,1'b1,1'b1,2'b00, 4'd6},  // R6 squash
    '{1'b0,1'b1,1'b0,1'b1,5'd1,5'd2,5'd1,1'b0,1'b0, 1'b0,1'b0,1'b0,2'b00, 4'd10}, // R10 branch wins
    '{1'b0,1'b0,1'b0,1'b0,5'd1,5'd2,5'd3,1'b0,1'b0, 1'b1,1'b1,1'b1,2'b00, 4'd9}   // R9 resolve
  };

  logic       clk = 1'b0;
  logic       rst;
  logic       jump, branch, alu_zero, ex_mem_read, id_use_imm, id_use_shamt;
  logic [4:0] id_rs, id_rt, ex_rt;
  logic       pc_we, ifid_we, bubble;
  logic [1:0] pc_sel;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  hazard_stall_ctrl #(.AW(5)) i_hazard_stall_ctrl (
    .clk(clk), .rst(rst), .jump(jump), .branch(branch), .alu_zero(alu_zero),
    .ex_mem_read(ex_mem_read), .id_rs(id_rs), .id_rt(id_rt), .ex_rt(ex_rt),
    .id_use_imm(id_use_imm), .id_use_shamt(id_use_shamt),
    .pc_we(pc_we), .ifid_we(ifid_we), .bubble(bubble), .pc_sel(pc_sel)
  );

  task automatic drive(input vec_t v);
    jump = v.jmp; branch = v.br; alu_zero = v.zero; ex_mem_read = v.mrd;
    id_rs = v.rs; id_rt = v.rt; ex_rt = v.prt; id_use_imm = v.imm; id_use_shamt = v.sh;
  endtask

  task automatic check(input string tag, input logic [4:0] exp);
    logic [4:0] act;
    act = {pc_we, ifid_we, bubble, pc_sel};
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: {pc_we,ifid_we,bubble,pc_sel} actual=%b expected=%b", tag, act, exp);
    end
  endtask

  localparam vec_t QUIET = '{1'b0,1'b0,1'b0,1'b0,5'd1,5'd2,5'd3,1'b0,1'b0,
                             1'b1,1'b1,1'b0,2'b00,4'd1};
  localparam vec_t BRV   = '{1'b0,1'b1,1'b0,1'b0,5'd1,5'd2,5'd3,1'b0,1'b0,
                             1'b0,1'b0,1'b0,2'b00,4'd7};

  initial begin
    rst = 1'b1;
    drive(QUIET);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #2 check("R1 after reset", 5'b11000);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(TBL[i]);
      #2 check($sformatf("R%0d row %0d", TBL[i].req, i),
               {TBL[i].e_pc, TBL[i].e_if, TBL[i].e_bub, TBL[i].e_sel});
    end

    // R1: reset arriving in the branch-wait state
    @(negedge clk);
    drive(BRV);
    #2 check("R7 branch before reset", 5'b00000);
    @(negedge clk);
    drive(QUIET);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    #2 check("R1 reset mid-branch", 5'b11000);

    // R11: load hazard during jump follow-up has no effect
    @(negedge clk);
    drive('{1'b1,1'b0,1'b0,1'b0,5'd1,5'd2,5'd3,1'b0,1'b0,1'b1,1'b0,1'b0,2'b01,4'd6});
    #2 check("R6 jump", 5'b10001);
    @(negedge clk);
    drive('{1'b0,1'b0,1'b0,1'b1,5'd4,5'd2,5'd4,1'b0,1'b0,1'b1,1'b1,1'b1,2'b00,4'd11});
    #2 check("R11 hazard in jump state", 5'b11100);
    @(negedge clk);
    #2 check("R5 hazard back in run", 5'b00100);
    @(negedge clk);
    drive(QUIET);
    #2 check("R2 quiet end", 5'b11000);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #100000;
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule